// File: doc/BRIEF.md
# Predicated Halfword Vector Load Sequencer

This block carries out one masked, contiguous load of unsigned 16-bit values into a vector of `VLEN` bits. A caller presents a decoded request for one cycle. The request holds the element width, a 64-bit base, a 64-bit starting index, a flag that selects the stack pointer as base, a predicate mask with one bit per vector byte, and the field number of the index register. The block then walks the elements from lane 0 upward. Each lane's address is the base plus twice a running index. Only lanes whose predicate bit is set cause a halfword read on a single-outstanding valid/ready memory port. The returned 16 bits are zero-extended into the lane. All other lanes are left at zero.

When the last lane has been handled, the full vector is presented with a one-cycle completion pulse. Two kinds of request are rejected before any memory traffic. The first is a malformed request, which raises a one-cycle illegal flag. The second is a stack-pointer base that is not 16-byte aligned while at least one lane is active, which raises a one-cycle misalignment flag. Requests that arrive while a load is in progress are ignored.

Top module: `hvl_pred_loader`

## Requirements
- R1: The read address for lane e is base + 2 × (start index + e), computed modulo 2^64.
- R2: A lane whose predicate bit is 0 issues no memory read, and its whole element in the result is zero.
- R3: An active lane places the 16 returned bits at bit position e × esize of the result, with the upper esize−16 bits of that element zero.
- R4: The width code selects the element size: 01 = 16 bits, 10 = 32 bits, 11 = 64 bits. The lane count is VLEN/esize. The predicate bit for lane e is mask bit e × (esize/8), and all other mask bits are ignored.
- R5: The running index advances once per lane, whether or not that lane is active, so the address of an active lane depends only on its lane number.
- R6: A request is illegal when its index-register field is 31 or its width code is 00. An illegal request produces a one-cycle `illegal` pulse in the cycle after it is presented, with no memory read and no `done`.
- R7: When `req_use_sp` is 1, the base is `sp_value`. If at least one lane is active and `sp_value[3:0]` is non-zero, the request produces a one-cycle `sp_misalign` pulse with no read and no `done`. If no lane is active, a misaligned `sp_value` is accepted and the load completes with an all-zero result.
- R8: `mem_req_valid` and `mem_addr` are held until `mem_req_ready`. At most one read is outstanding. The response is accepted either in the same cycle as `mem_req_ready` or in a later cycle via `mem_rsp_valid`.
- R9: After the last lane, `done` is high for exactly one cycle, with `result` holding the whole vector. Each accepted request yields exactly one of `done`, `illegal` or `sp_misalign`. A `req_valid` seen while `busy` is ignored.
- R10: After reset the block is idle: `busy`, `done`, `illegal`, `sp_misalign` and `mem_req_valid` are 0 and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_es | input | 2 | Element width code (01/10/11) |
| req_idx_field | input | 5 | Index-register field number; 31 is illegal |
| req_base | input | 64 | Base address when not using the stack pointer |
| req_index | input | 64 | Starting element index |
| req_use_sp | input | 1 | Take base from `sp_value` |
| req_mask | input | VLEN/8 | Predicate mask, one bit per vector byte |
| sp_value | input | 64 | Current stack pointer |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | VLEN | Loaded vector, valid with `done` |
| illegal | output | 1 | One-cycle illegal-request pulse |
| sp_misalign | output | 1 | One-cycle stack-pointer alignment fault pulse |
| mem_req_valid | output | 1 | Read request valid |
| mem_addr | output | 64 | Read byte address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 16 | Returned halfword |

## Verification
The request handshake and the data return can coincide: `mem_req_ready` and `mem_rsp_valid` may both be high in one cycle, and the block must then capture the data and move to the next lane without entering its wait state. The bench's memory model rotates through four behaviours per access: same-cycle response, a one-cycle delayed response, a two-cycle stall followed by a same-cycle response, and a three-cycle delayed response. Every access address is compared against the queued expectation at the moment it is accepted. Every completed vector is compared against the expected result, so a lost or duplicated capture in the coinciding case shows up as a wrong lane or a surplus read.

// File: rtl/hvl_pkg.sv
package hvl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_REQ  = 2'd2,
        ST_WAIT = 2'd3
    } hvl_state_e;

    localparam logic [1:0] ES_16 = 2'b01;
    localparam logic [1:0] ES_32 = 2'b10;
    localparam logic [1:0] ES_64 = 2'b11;
    localparam logic [1:0] ES_BAD = 2'b00;

    localparam logic [4:0] IDX_FIELD_BAD = 5'd31;
    localparam int HALF_W = 16;
    localparam int SP_ALIGN_BITS = 4;

endpackage

// File: rtl/hvl_lane_geom.sv
module hvl_lane_geom
    import hvl_pkg::*;
#(
    parameter int VLEN = 128,
    localparam int PW  = VLEN / 8,
    localparam int EW  = $clog2(VLEN / 16),
    localparam int OW  = $clog2(VLEN),
    localparam int PSW = $clog2(VLEN / 8)
) (
    input  logic [1:0]    es_code,
    input  logic [EW-1:0] elem,
    input  logic [PW-1:0] mask,
    output logic [EW-1:0] last_elem,
    output logic          pred,
    output logic [OW-1:0] bit_off
);

    logic [PSW-1:0] pidx;

    always_comb begin
        case (es_code)
            ES_32: begin
                last_elem = EW'(VLEN / 32 - 1);
                pidx      = {elem[EW-2:0], 2'b00};
                bit_off   = {elem[EW-2:0], 5'b00000};
            end
            ES_64: begin
                last_elem = EW'(VLEN / 64 - 1);
                pidx      = {elem[EW-3:0], 3'b000};
                bit_off   = {elem[EW-3:0], 6'b000000};
            end
            default: begin
                last_elem = EW'(VLEN / 16 - 1);
                pidx      = {elem, 1'b0};
                bit_off   = {elem, 4'b0000};
            end
        endcase
        pred = mask[pidx];
    end

endmodule

// File: rtl/hvl_active_scan.sv
module hvl_active_scan
    import hvl_pkg::*;
#(
    parameter int VLEN = 128,
    localparam int PW  = VLEN / 8
) (
    input  logic [1:0]    es_code,
    input  logic [PW-1:0] mask,
    output logic          any_act
);

    logic [PW-1:0] sel16;
    logic [PW-1:0] sel32;
    logic [PW-1:0] sel64;

    for (genvar b = 0; b < PW; b++) begin : g_pos
        assign sel16[b] = ((b % 2) == 0);
        assign sel32[b] = ((b % 4) == 0);
        assign sel64[b] = ((b % 8) == 0);
    end

    always_comb begin
        case (es_code)
            ES_32:   any_act = |(mask & sel32);
            ES_64:   any_act = |(mask & sel64);
            default: any_act = |(mask & sel16);
        endcase
    end

endmodule

// File: rtl/hvl_pred_loader.sv
module hvl_pred_loader
    import hvl_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int AW   = 64,
    localparam int PW  = VLEN / 8,
    localparam int EW  = $clog2(VLEN / 16),
    localparam int OW  = $clog2(VLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_es,
    input  logic [4:0]      req_idx_field,
    input  logic [AW-1:0]   req_base,
    input  logic [AW-1:0]   req_index,
    input  logic            req_use_sp,
    input  logic [PW-1:0]   req_mask,
    input  logic [AW-1:0]   sp_value,
    output logic            busy,
    output logic            done,
    output logic [VLEN-1:0] result,
    output logic            illegal,
    output logic            sp_misalign,
    output logic            mem_req_valid,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_req_ready,
    input  logic            mem_rsp_valid,
    input  logic [HALF_W-1:0] mem_rsp_data
);

    typedef struct packed {
        hvl_state_e    st;
        logic [1:0]    es;
        logic [AW-1:0] base;
        logic [AW-1:0] idx;
        logic [PW-1:0] mask;
        logic [EW-1:0] elem;
        logic [VLEN-1:0] vec;
        logic          done;
        logic          ill;
        logic          mis;
    } ld_state_t;

    ld_state_t s_d, s_q;

    logic          req_any_act;
    logic [EW-1:0] cur_last;
    logic          cur_pred;
    logic [OW-1:0] cur_off;
    logic          capture;
    logic          advance;
    logic          req_bad;
    logic          sp_off;

    hvl_active_scan #(.VLEN(VLEN)) u_scan (
        .es_code (req_es),
        .mask    (req_mask),
        .any_act (req_any_act)
    );

    hvl_lane_geom #(.VLEN(VLEN)) u_geom (
        .es_code   (s_q.es),
        .elem      (s_q.elem),
        .mask      (s_q.mask),
        .last_elem (cur_last),
        .pred      (cur_pred),
        .bit_off   (cur_off)
    );

    assign req_bad = (req_idx_field == IDX_FIELD_BAD) || (req_es == ES_BAD);
    assign sp_off  = |sp_value[SP_ALIGN_BITS-1:0];

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.ill  = 1'b0;
        s_d.mis  = 1'b0;
        capture  = 1'b0;
        advance  = 1'b0;

        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_bad) begin
                        s_d.ill = 1'b1;
                    end else if (req_use_sp && req_any_act && sp_off) begin
                        s_d.mis = 1'b1;
                    end else begin
                        s_d.st   = ST_STEP;
                        s_d.es   = req_es;
                        s_d.base = req_use_sp ? sp_value : req_base;
                        s_d.idx  = req_index;
                        s_d.mask = req_mask;
                        s_d.elem = '0;
                        s_d.vec  = '0;
                    end
                end
            end
            ST_STEP: begin
                if (cur_pred) begin
                    s_d.st = ST_REQ;
                end else begin
                    advance = 1'b1;
                end
            end
            ST_REQ: begin
                if (mem_req_ready) begin
                    if (mem_rsp_valid) begin
                        capture = 1'b1;
                        advance = 1'b1;
                    end else begin
                        s_d.st = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    capture = 1'b1;
                    advance = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (capture) begin
            s_d.vec[cur_off +: HALF_W] = mem_rsp_data;
        end

        if (advance) begin
            s_d.idx = s_q.idx + AW'(1);
            if (s_q.elem == cur_last) begin
                s_d.st   = ST_IDLE;
                s_d.done = 1'b1;
            end else begin
                s_d.elem = s_q.elem + EW'(1);
                s_d.st   = ST_STEP;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy          = (s_q.st != ST_IDLE);
    assign done          = s_q.done;
    assign illegal       = s_q.ill;
    assign sp_misalign   = s_q.mis;
    assign result        = s_q.vec;
    assign mem_req_valid = (s_q.st == ST_REQ);
    assign mem_addr      = s_q.base + (s_q.idx << 1);

endmodule

// File: rtl/hvl_pred_loader_chk.sv
module hvl_pred_loader_chk #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          illegal,
    input logic          sp_misalign,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [AW-1:0] mem_addr
);

    p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

    p_req_in_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, illegal, sp_misalign}));

    p_illegal_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!busy && !mem_req_valid));

    p_misalign_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sp_misalign |-> (!busy && !mem_req_valid));

endmodule

bind hvl_pred_loader hvl_pred_loader_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .done          (done),
    .illegal       (illegal),
    .sp_misalign   (sp_misalign),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_addr      (mem_addr)
);

// File: tb/tb_hvl_pred_loader.sv
`timescale 1ns/1ps
module tb_hvl_pred_loader;

    localparam int VLEN = 128;
    localparam int PW   = VLEN / 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [1:0]      req_es = 2'b01;
    logic [4:0]      req_idx_field = 5'd0;
    logic [63:0]     req_base = '0;
    logic [63:0]     req_index = '0;
    logic            req_use_sp = 1'b0;
    logic [PW-1:0]   req_mask = '0;
    logic [63:0]     sp_value = '0;
    logic            busy, done, illegal, sp_misalign, mem_req_valid;
    logic [VLEN-1:0] result;
    logic [63:0]     mem_addr;
    logic            mem_req_ready;
    logic            mem_rsp_valid;
    logic [15:0]     mem_rsp_data;

    always #2.5 clk = ~clk;

    hvl_pred_loader #(.VLEN(VLEN), .AW(64)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_es(req_es),
        .req_idx_field(req_idx_field), .req_base(req_base), .req_index(req_index),
        .req_use_sp(req_use_sp), .req_mask(req_mask), .sp_value(sp_value),
        .busy(busy), .done(done), .result(result), .illegal(illegal),
        .sp_misalign(sp_misalign), .mem_req_valid(mem_req_valid), .mem_addr(mem_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    typedef struct {
        logic [2:0]      kind;   // {done, illegal, sp_misalign}
        logic [VLEN-1:0] vec;
    } exp_t;

    exp_t        exp_q[$];
    logic [63:0] addr_q[$];
    int          n_chk = 0;
    int          n_bad = 0;
    int          acc_cnt = 0;

    function automatic logic [15:0] memfn(input logic [63:0] a);
        return a[16:1] ^ a[32:17] ^ 16'hA5C3;
    endfunction

    task automatic note(input bit ok, input string req, input string what,
                        input logic [VLEN-1:0] act, input logic [VLEN-1:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // memory model: rotates handshake/response timing per access
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            if (rst_n && mem_req_valid) begin
                automatic int mode = acc_cnt % 4;
                automatic logic [63:0] a0 = mem_addr;
                automatic logic [63:0] ea;
                acc_cnt++;
                if (mode == 2) repeat (2) @(negedge clk);
                note(mem_req_valid && (mem_addr == a0), "R8", "request held during stall",
                     VLEN'(mem_addr), VLEN'(a0));
                if (addr_q.size() == 0) begin
                    note(1'b0, "R2", "unexpected memory read", VLEN'(mem_addr), '0);
                end else begin
                    ea = addr_q.pop_front();
                    note(mem_addr == ea, "R1/R5", "read address", VLEN'(mem_addr), VLEN'(ea));
                end
                mem_req_ready = 1'b1;
                if (mode == 1 || mode == 3) begin
                    @(negedge clk);
                    mem_req_ready = 1'b0;
                    repeat (mode - 1) @(negedge clk);
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = memfn(a0);
                    @(negedge clk);
                    mem_rsp_valid = 1'b0;
                end else begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = memfn(a0);
                    @(negedge clk);
                    mem_req_ready = 1'b0;
                    mem_rsp_valid = 1'b0;
                end
            end
        end
    end

    // monitor: scoreboard pop and compare
    exp_t mon_it;
    always @(negedge clk) begin
        if (rst_n && (done || illegal || sp_misalign)) begin
            if (exp_q.size() == 0) begin
                note(1'b0, "R9", "unexpected outcome pulse",
                     VLEN'({done, illegal, sp_misalign}), '0);
            end else begin
                mon_it = exp_q.pop_front();
                note({done, illegal, sp_misalign} == mon_it.kind, "R6/R7/R9", "outcome kind",
                     VLEN'({done, illegal, sp_misalign}), VLEN'(mon_it.kind));
                if (mon_it.kind == 3'b100)
                    note(result == mon_it.vec, "R2/R3/R4", "result vector", result, mon_it.vec);
            end
        end
    end

    task automatic run_req(input logic [1:0] es, input logic [4:0] fld,
                           input logic [63:0] base, input logic [63:0] idx,
                           input logic use_sp, input logic [PW-1:0] mask,
                           input logic [63:0] sp, input bit junk);
        exp_t        it;
        int          esb;
        int          lanes;
        logic        any;
        logic [63:0] b;
        logic [63:0] a;
        it.vec = '0;
        any    = 1'b0;
        if (fld == 5'd31 || es == 2'b00) begin
            it.kind = 3'b010;                       // R6
        end else begin
            esb   = 8 << es;                        // R4: 01->16, 10->32, 11->64
            lanes = VLEN / esb;
            b     = use_sp ? sp : base;             // R7
            for (int e = 0; e < lanes; e++)
                if (mask[e * (esb / 8)]) any = 1'b1;
            if (use_sp && any && (sp[3:0] != 4'd0)) begin
                it.kind = 3'b001;                   // R7
            end else begin
                it.kind = 3'b100;
                for (int e = 0; e < lanes; e++) begin
                    if (mask[e * (esb / 8)]) begin
                        a = b + ((idx + 64'(e)) << 1);  // R1, R5
                        addr_q.push_back(a);
                        it.vec[e * esb +: 16] = memfn(a); // R3
                    end
                end
            end
        end
        exp_q.push_back(it);
        @(negedge clk);
        req_valid     = 1'b1;
        req_es        = es;
        req_idx_field = fld;
        req_base      = base;
        req_index     = idx;
        req_use_sp    = use_sp;
        req_mask      = mask;
        sp_value      = sp;
        @(negedge clk);
        req_valid = 1'b0;
        if (junk) begin
            repeat (2) @(negedge clk);
            req_valid     = 1'b1;                   // R9: ignored while busy
            req_idx_field = 5'd31;
            req_mask      = 16'hFFFF;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (exp_q.size() != 0 || addr_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog expired: actual %0d pending expected 0", exp_q.size());
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        note(!busy && !done && !illegal && !sp_misalign && !mem_req_valid, "R10",
             "idle flags in reset", VLEN'({busy, done, illegal, sp_misalign, mem_req_valid}), '0);
        note(result == '0, "R10", "result cleared in reset", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        note(!busy && !mem_req_valid, "R10", "idle after reset release",
             VLEN'({busy, mem_req_valid}), '0);

        // R1 R3 R4 R5: 16-bit lanes, all active
        run_req(2'b01, 5'd3, 64'h0000_0000_0000_1000, 64'd5, 1'b0, 16'hFFFF, '0, 1'b0);
        // R2 R4: 16-bit, partial mask; odd bits must be ignored
        run_req(2'b01, 5'd4, 64'h0000_0000_8000_0000, 64'd0, 1'b0, 16'b1010_0101_0011_0100, '0, 1'b0);
        // R4: 32-bit lanes, lanes 1 and 3 active, non-predicate bits set
        run_req(2'b10, 5'd7, 64'h0000_1234_0000_0002, 64'd9, 1'b0, 16'h1E1E, '0, 1'b0);
        // R4: 32-bit, all lanes
        run_req(2'b10, 5'd0, 64'h0000_0000_0000_4000, 64'd100, 1'b0, 16'hFFFF, '0, 1'b0);
        // R1: 64-bit lanes, address wraps modulo 2^64
        run_req(2'b11, 5'd1, 64'hFFFF_FFFF_FFFF_FFF0, 64'd7, 1'b0, 16'h0101, '0, 1'b0);
        // R1 R5: index wraps, lane 0 inactive but index still advances
        run_req(2'b01, 5'd2, 64'h0000_0000_0000_0100, 64'hFFFF_FFFF_FFFF_FFFD, 1'b0, 16'hFFFC, '0, 1'b0);
        // R6: index field 31, then width code 00
        run_req(2'b01, 5'd31, 64'h0000_0000_0000_2000, 64'd0, 1'b0, 16'hFFFF, '0, 1'b0);
        run_req(2'b00, 5'd5, 64'h0000_0000_0000_2000, 64'd0, 1'b0, 16'hFFFF, '0, 1'b0);
        // R7: aligned stack pointer base overrides req_base
        run_req(2'b11, 5'd6, 64'hDEAD_BEEF_0000_0000, 64'd3, 1'b1, 16'h0001, 64'h0000_0000_2000_0040, 1'b0);
        // R7: misaligned stack pointer with an active lane
        run_req(2'b10, 5'd6, 64'd0, 64'd0, 1'b1, 16'h0010, 64'h0000_0000_2000_0048, 1'b0);
        // R7 R2: misaligned stack pointer, no active lane (only odd bits set)
        run_req(2'b01, 5'd6, 64'd0, 64'd0, 1'b1, 16'hAAAA, 64'h0000_0000_2000_0003, 1'b0);
        // R9: second request while busy is ignored
        run_req(2'b01, 5'd8, 64'h0000_0000_0000_6000, 64'd1, 1'b0, 16'h5555, '0, 1'b1);
        // R2: everything inactive, 64-bit width
        run_req(2'b11, 5'd9, 64'h0000_0000_0000_7000, 64'd0, 1'b0, 16'hFEFE, '0, 1'b0);

        note(addr_q.size() == 0, "R2", "no leftover expected reads", VLEN'(addr_q.size()), '0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule